// File: doc/BRIEF.md
# Forwarded Interrupt Capture Controller

This block relays an interrupt raised by a device further down a chain to a local host. The downstream side signals by pulling an active-low line low. When two enable bits in a control register are both set, the block captures the high-to-low transition of that line as a pending flag. While the flag is pending and forwarding is enabled, it pulls its own active-low output low toward the host.

The host reads the status register to learn the cause. That read returns the flag and clears it, which releases the output. The downstream source is cleared separately, outside this block. A new interrupt is captured only when the incoming line falls again, so a line that is still held low never fires twice. The input passes through a synchronizer before edge detection, so it may be fully asynchronous to the block clock.

Top module: `fwd_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the interrupt output is high, the control register reads 0 and the status register reads 0. The input history counts as high.
- R2: With control bit 0 (global enable) and control bit 5 (remote enable) both set, a falling edge on the input sets the pending flag. The output goes low on the third rising clock edge after the input falls.
- R3: A falling edge that arrives while either enable bit is clear is not captured, and setting the enables later while the input stays low does not capture it.
- R4: A read of the status register (address 1) returns the flag in bit 0 as it was before the read, with all other bits 0. It clears the flag and releases the output from the next clock edge. A read of the control register does not clear the flag.
- R5: After a clear, an input that stays low does not set the flag again.
- R6: After the input returns high, its next falling edge sets the flag again.
- R7: If a captured falling edge and a status read fall in the same cycle, the flag stays set and the output stays low.
- R8: Clearing either enable bit releases the output from the next clock edge but keeps the flag. Setting both enables again drives the output low without a new edge.
- R9: A write to the control register (address 0) stores the whole data word, and a control read returns it. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_n_in | input | 1 | Downstream interrupt line, active low, asynchronous |
| irq_n_out | output | 1 | Host interrupt line, active low |
| bus_addr | input | AW (4) | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data, valid in the cycle of the read strobe |

## Verification
The bench sweeps all four combinations of the two enable bits against a falling edge on the input. Only the combination with both bits set may raise the output, and each case also checks that enabling late, after the edge, captures nothing. A line held low across a clear separates edge capture from level capture, and a release followed by a fresh fall shows that the block re-arms. A status read placed exactly on the capture cycle tests which side wins the collision. Enable toggling with a pending flag separates masking of the output from discarding of the flag.

// File: rtl/fwd_irq_pkg.sv
package fwd_irq_pkg;

   // kind of register access decoded from the bus strobes
   typedef enum logic [1:0] {
      ACC_NONE    = 2'd0,
      ACC_CTRL_RD = 2'd1,
      ACC_STAT_RD = 2'd2,
      ACC_CTRL_WR = 2'd3
   } acc_e;

   localparam int DEF_DW          = 8;
   localparam int DEF_AW          = 4;
   localparam int DEF_SYNC_STAGES = 2;
   localparam int DEF_GIE_BIT     = 0;
   localparam int DEF_RIE_BIT     = 5;

endpackage

// File: rtl/fwd_irq_sync.sv
module fwd_irq_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("fwd_irq_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[LAST-1:0], d};
      end
   end

   assign q = chain_q[LAST];

endmodule

// File: rtl/fwd_irq_edge.sv
module fwd_irq_edge #(
   parameter logic IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic fall
);

   logic hist_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_q <= IDLE_VAL;
      end else begin
         hist_q <= lvl;
      end
   end

   assign fall = hist_q & ~lvl;

   // R5
   single_fall_chk: assert property (@(posedge clk) disable iff (rst)
      fall |=> !fall)
      else $error("falling edge reported on two cycles in a row");

endmodule

// File: rtl/fwd_irq_regs.sv
module fwd_irq_regs
   import fwd_irq_pkg::*;
#(
   parameter int             DW        = DEF_DW,
   parameter int             AW        = DEF_AW,
   parameter logic [AW-1:0]  CTRL_ADDR = 'h0,
   parameter logic [AW-1:0]  STAT_ADDR = 'h1,
   parameter int             GIE_BIT   = DEF_GIE_BIT,
   parameter int             RIE_BIT   = DEF_RIE_BIT
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          pend,
   output logic          en_both,
   output logic          stat_rd
);

   localparam int PAD_W = DW - 1;

   if (GIE_BIT >= DW || RIE_BIT >= DW) begin : g_bad_bits
      $error("fwd_irq_regs: enable bit outside the data word");
   end
   if (GIE_BIT == RIE_BIT) begin : g_same_bits
      $error("fwd_irq_regs: enable bits must differ");
   end
   if (CTRL_ADDR == STAT_ADDR) begin : g_same_addr
      $error("fwd_irq_regs: register addresses must differ");
   end

   acc_e          acc;
   logic [DW-1:0] ctrl_q;

   // writes take priority over a read in the same cycle
   always_comb begin
      acc = ACC_NONE;
      if (bus_wr) begin
         if (bus_addr == CTRL_ADDR) acc = ACC_CTRL_WR;
      end else if (bus_rd) begin
         if (bus_addr == CTRL_ADDR)      acc = ACC_CTRL_RD;
         else if (bus_addr == STAT_ADDR) acc = ACC_STAT_RD;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
      end else if (acc == ACC_CTRL_WR) begin
         ctrl_q <= bus_wdata;
      end
   end

   always_comb begin
      unique case (acc)
         ACC_CTRL_RD: bus_rdata = ctrl_q;
         ACC_STAT_RD: bus_rdata = {{PAD_W{1'b0}}, pend};
         default:     bus_rdata = '0;
      endcase
   end

   assign en_both = ctrl_q[GIE_BIT] & ctrl_q[RIE_BIT];
   assign stat_rd = (acc == ACC_STAT_RD);

   // R9
   ctrl_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == CTRL_ADDR) |=> (ctrl_q == $past(bus_wdata)))
      else $error("control register did not take the written word");

endmodule

// File: rtl/fwd_irq_ctrl.sv
module fwd_irq_ctrl
   import fwd_irq_pkg::*;
#(
   parameter int            DW          = DEF_DW,
   parameter int            AW          = DEF_AW,
   parameter int            SYNC_STAGES = DEF_SYNC_STAGES,
   parameter logic [AW-1:0] CTRL_ADDR   = 'h0,
   parameter logic [AW-1:0] STAT_ADDR   = 'h1,
   parameter int            GIE_BIT     = DEF_GIE_BIT,
   parameter int            RIE_BIT     = DEF_RIE_BIT
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          irq_n_in,
   output logic          irq_n_out,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata
);

   logic in_sync;
   logic fall;
   logic en_both;
   logic stat_rd;
   logic pend_q;
   logic capture;

   fwd_irq_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (irq_n_in),
      .q   (in_sync)
   );

   fwd_irq_edge #(
      .IDLE_VAL (1'b1)
   ) u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (in_sync),
      .fall (fall)
   );

   fwd_irq_regs #(
      .DW        (DW),
      .AW        (AW),
      .CTRL_ADDR (CTRL_ADDR),
      .STAT_ADDR (STAT_ADDR),
      .GIE_BIT   (GIE_BIT),
      .RIE_BIT   (RIE_BIT)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pend      (pend_q),
      .en_both   (en_both),
      .stat_rd   (stat_rd)
   );

   assign capture = fall & en_both;

   // a new event outranks a clearing read
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
      end else if (capture) begin
         pend_q <= 1'b1;
      end else if (stat_rd) begin
         pend_q <= 1'b0;
      end
   end

   assign irq_n_out = ~(pend_q & en_both);

   // R2 R7
   capture_chk: assert property (@(posedge clk) disable iff (rst)
      (fall && en_both) |=> pend_q)
      else $error("enabled falling edge was not captured");

   // R4
   clr_release_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_rd && !(fall && en_both)) |=> irq_n_out)
      else $error("status read did not release the output");

   // R3 R5
   no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
      (!pend_q && !(fall && en_both)) |=> !pend_q)
      else $error("flag set without an enabled falling edge");

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_q && !stat_rd) |=> pend_q)
      else $error("flag lost without a status read");

endmodule

// File: tb/fwd_irq_ctrl_test.sv
module fwd_irq_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int AW = 4;
   localparam logic [AW-1:0] A_CTRL = 4'h0;
   localparam logic [AW-1:0] A_STAT = 4'h1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          irq_n_in = 1'b1;
   logic          irq_n_out;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] rd_val;

   always #(CLK_PERIOD/2) clk = ~clk;

   fwd_irq_ctrl uut (
      .clk       (clk),
      .rst       (rst),
      .irq_n_in  (irq_n_in),
      .irq_n_out (irq_n_out),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] v);
      @(negedge clk);
      bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_in(input logic v, input int waits);
      @(negedge clk);
      irq_n_in = v;
      repeat (waits) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      check("R1 out", {7'b0, irq_n_out}, 8'h01);
      rd_reg(A_CTRL, rd_val); check("R1 ctrl", rd_val, 8'h00);
      rd_reg(A_STAT, rd_val); check("R1 stat", rd_val, 8'h00);

      // R9 control storage and stray writes
      wr_reg(A_CTRL, 8'hA5);
      rd_reg(A_CTRL, rd_val); check("R9 readback", rd_val, 8'hA5);
      wr_reg(4'h3, 8'hFF);
      rd_reg(A_CTRL, rd_val); check("R9 stray write", rd_val, 8'hA5);
      wr_reg(A_CTRL, 8'h00);

      // R2 R3 sweep over enable combinations
      for (int en = 0; en < 4; en++) begin
         logic exp_hit;
         exp_hit = (en == 3);
         wr_reg(A_CTRL, {2'b0, en[1], 4'b0, en[0]});
         set_in(1'b0, 4);
         check($sformatf("R2 R3 out en=%0d", en), {7'b0, irq_n_out}, {7'b0, !exp_hit});
         if (exp_hit) begin
            rd_reg(A_CTRL, rd_val);
            check("R4 ctrl read keeps flag", {7'b0, irq_n_out}, 8'h00);
         end else begin
            wr_reg(A_CTRL, 8'h21);
            repeat (3) @(negedge clk);
            check($sformatf("R3 late enable en=%0d", en), {7'b0, irq_n_out}, 8'h01);
         end
         rd_reg(A_STAT, rd_val);
         check($sformatf("R4 stat en=%0d", en), rd_val, {7'b0, exp_hit});
         check($sformatf("R4 release en=%0d", en), {7'b0, irq_n_out}, 8'h01);
         set_in(1'b1, 4);
      end

      // R5 held low after clear
      wr_reg(A_CTRL, 8'h21);
      set_in(1'b0, 4);
      check("R5 first capture", {7'b0, irq_n_out}, 8'h00);
      rd_reg(A_STAT, rd_val);
      check("R5 cleared", {7'b0, irq_n_out}, 8'h01);
      repeat (10) @(negedge clk);
      check("R5 no refire out", {7'b0, irq_n_out}, 8'h01);
      rd_reg(A_STAT, rd_val); check("R5 no refire stat", rd_val, 8'h00);

      // R6 re-arm on a fresh edge
      set_in(1'b1, 4);
      set_in(1'b0, 4);
      check("R6 recapture", {7'b0, irq_n_out}, 8'h00);

      // R8 enable masking keeps the flag
      wr_reg(A_CTRL, 8'h01);
      check("R8 mask releases", {7'b0, irq_n_out}, 8'h01);
      wr_reg(A_CTRL, 8'h20);
      check("R8 other mask releases", {7'b0, irq_n_out}, 8'h01);
      wr_reg(A_CTRL, 8'h21);
      check("R8 flag retained", {7'b0, irq_n_out}, 8'h00);

      // R7 capture collides with status read
      set_in(1'b1, 4);
      check("R7 pending before", {7'b0, irq_n_out}, 8'h00);
      @(negedge clk);
      irq_n_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      bus_addr = A_STAT; bus_rd = 1'b1;
      #1 check("R7 read value", bus_rdata, 8'h01);
      @(negedge clk);
      bus_rd = 1'b0;
      check("R7 flag survives", {7'b0, irq_n_out}, 8'h00);
      rd_reg(A_STAT, rd_val);
      check("R7 later read", rd_val, 8'h01);
      check("R7 cleared after", {7'b0, irq_n_out}, 8'h01);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule